// File: doc/BRIEF.md
# Clause 22 MDIO Management Master with a Single Command Register

This block lets software reach the management registers of an Ethernet PHY through one 32-bit access word. Software writes a word that holds the start flag, the direction, the PHY and register addresses and, for a write, the data. The block then serialises a complete clause 22 management frame on MDC and MDIO. While the frame runs, the busy flag reads back as 1. When the frame ends the flag clears by itself, and after a read the low half of the same word holds the value the PHY returned.

MDC is made by dividing the system clock by `2*MDC_HALF_CYC`. The master changes MDIO only just after a falling MDC edge and samples the PHY on rising edges. When no frame is running, MDC rests low and MDIO is released.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, reg_rdata is 0, mdc is 0, mdio_oe is 0 and mdio_o is 1.
- R2: A write with bit 31 set, made while idle, starts a frame. Bit 31 of reg_rdata then reads 1 for exactly 128*MDC_HALF_CYC clock cycles and clears by itself. reg_rdata reads as {busy, bit 30, 4'b0000, PHY address in 25:21, register address in 20:16, data in 15:0}.
- R3: Bit 30 sets the direction. A 1 gives a read with opcode bits 1,0 on the wire. A 0 gives a write with opcode bits 0,1.
- R4: Each frame starts with 32 one bits. Next come the start pattern 0,1, then the two opcode bits, then the 5-bit PHY address and the 5-bit register address, both MSB first.
- R5: In a write frame, the two bits after the addresses are 1,0, followed by the 16 data bits from reg_wdata[15:0], MSB first. mdio_oe stays 1 for all 64 bits.
- R6: In a read frame, mdio_oe is 1 for the first 46 bits and 0 for the last 18. On the rising MDC edges of the last 16 bits, the master samples mdio_i MSB first. That value is in reg_rdata[15:0] by the time busy clears.
- R7: A write made while busy is 1 changes neither the running frame nor the reg_rdata fields.
- R8: MDC stays low when idle and has a period of 2*MDC_HALF_CYC clocks during a frame. mdio_o changes only in the clock cycle in which MDC falls.
- R9: A write with bit 31 clear, made while idle, starts nothing and leaves reg_rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the access word |
| reg_wdata | input | 32 | Command word written by software |
| reg_rdata | output | 32 | Busy flag, command fields and data or read result |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Serial data from the PHY |

## Verification
Busy is visible on the clock edge that samples the write strobe. It falls exactly 128*MDC_HALF_CYC edges later, on the same edge where the last MDC fall happens. The bench therefore counts the falling clock edges on which busy reads 1 and compares that count with the formula.

Frame bits and the drive enable only change at an MDC fall. A monitor samples them at each MDC rise, where they are steady, and compares them against a frame that the driver task built and queued. The monitor also checks the MDC period. The PHY model in the bench drives read data one time unit after the previous rising edge.

The read result and the unchanged fields are checked on the first falling clock edge after busy clears.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int START_BIT  = 31;
    localparam int RD_BIT     = 30;
    localparam int PHY_LSB    = 21;
    localparam int REG_LSB    = 16;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] pay;
        op  = c.rd ? 2'b10 : 2'b01;
        ta  = c.rd ? 2'b11 : 2'b10;
        pay = c.rd ? 16'hFFFF : c.data;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, ta, pay};
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int MDC_HALF_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = $clog2(MDC_HALF_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MDC_HALF_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t st_d, st_q;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = run && (st_q.cnt == LAST_CNT);
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc      = st_q.mdc;
    assign rise_stb = wrap && !st_q.mdc;
    assign fall_stb = wrap &&  st_q.mdc;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_word,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [15:0]           rsh;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.rd   = cmd.rd;
                st_d.idx  = '0;
                st_d.sh   = build_frame(cmd);
            end
        end else begin
            if (rise_stb && st_q.rd && (st_q.idx >= IDX_W'(DATA_POS)))
                st_d.rsh = {st_q.rsh[14:0], mdio_i};
            if (fall_stb) begin
                if (st_q.idx == LAST_IDX) begin
                    st_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign rd_word = st_q.rsh;
    assign mdio_o  = st_q.busy ? st_q.sh[FRAME_BITS-1] : 1'b1;
    assign mdio_oe = st_q.busy && (!st_q.rd || (st_q.idx < IDX_W'(TA_POS)));

    // R8
    mdio_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_o != $past(mdio_o)) |-> $past(fall_stb));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int MDC_HALF_CYC = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   acc_d, acc_q, wr_cmd;
    logic        busy, done, start, rise_stb, fall_stb;
    logic [15:0] rd_word;
    logic        unused_wbits;

    assign unused_wbits = ^reg_wdata[29:26];
    assign wr_cmd = '{rd:    reg_wdata[RD_BIT],
                      phy:   reg_wdata[PHY_LSB +: 5],
                      regad: reg_wdata[REG_LSB +: 5],
                      data:  reg_wdata[15:0]};
    assign start  = reg_we && reg_wdata[START_BIT] && !busy;

    always_comb begin
        acc_d = acc_q;
        if (start)
            acc_d = wr_cmd;
        else if (done && acc_q.rd)
            acc_d.data = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign reg_rdata = {busy, acc_q.rd, 4'b0000, acc_q.phy, acc_q.regad, acc_q.data};

    mdio_mdc_gen #(.MDC_HALF_CYC(MDC_HALF_CYC)) u_mdc (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(wr_cmd),
        .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
        .busy(busy), .done(done), .rd_word(rd_word),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // R7
    fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(reg_rdata[30:16]));
    // R5
    write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && !reg_rdata[30]) |-> mdio_oe);
    // R2
    busy_ends_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[31]) |-> $fell(mdc));
    // R8
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mdc);
    // R9
    nostart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && reg_we && !reg_wdata[31]) |=> $stable(reg_rdata));
endmodule

// File: tb/mdio_cmd_master_tb.sv
module mdio_cmd_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;

    typedef struct packed {
        logic [63:0] bits;
        logic [63:0] oe;
        logic        rd;
        logic [15:0] resp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int   checks = 0;
    int   errors = 0;
    exp_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_cmd_master #(.MDC_HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard on the MDC rising edges, also PHY model
    initial begin
        int    k = 0;
        exp_t  cur = '0;
        bit    bad = 0;
        bit    perr = 0;
        int    badk = 0;
        longint tprev = 0;
        forever begin
            @(posedge mdc);
            if (k == 0) begin
                bad = 0; perr = 0; badk = 0;
                if (sbq.size() == 0) begin
                    cur = '0;
                    check(0, "R7/R9 unexpected frame", 64'd1, 64'd0);
                end else cur = sbq.pop_front();
            end else if (($time - tprev) != 2*HALF*CLK_PERIOD) perr = 1;
            tprev = $time;
            if (mdio_oe !== cur.oe[63-k]) begin
                if (!bad) badk = k; bad = 1;
            end else if (cur.oe[63-k] && (mdio_o !== cur.bits[63-k])) begin
                if (!bad) badk = k; bad = 1;
            end
            if (cur.rd && k >= 47 && k <= 62) begin
                #1 mdio_i = cur.resp[62-k];
            end
            if (k == 63) begin
                check(!bad, "R3/R4/R5/R6 frame bits (first bad bit index)", 64'(badk), 64'd0);
                check(!perr, "R8 mdc period", 64'(perr), 64'd0);
                mdio_i = 1'b1;
                k = 0;
            end else k++;
        end
    end

    task automatic run_cmd(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] data, input logic [15:0] resp, input bit poke);
        exp_t e;
        int   cnt;
        logic [31:0] exp_rd;
        e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
                  (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : data)};
        e.oe   = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        e.rd   = rd;
        e.resp = resp;
        sbq.push_back(e);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = {1'b1, rd, 4'b1111, phy, ra, data};
        @(negedge clk);
        reg_we = 1'b0;
        cnt = 0;
        while (reg_rdata[31] === 1'b1 && cnt < 5000) begin
            cnt++;
            if (poke && cnt == 100) begin
                reg_we = 1'b1;
                reg_wdata = {1'b1, ~rd, 4'b0, ~phy, ~ra, ~data};
            end else reg_we = 1'b0;
            @(negedge clk);
        end
        reg_we = 1'b0;
        check(cnt == 128*HALF, "R2 busy duration", 64'(cnt), 64'(128*HALF));
        exp_rd = {1'b0, rd, 4'b0000, phy, ra, (rd ? resp : data)};
        check(reg_rdata === exp_rd, poke ? "R7 fields after ignored write" :
              (rd ? "R6 read result" : "R2 readback"), 64'(reg_rdata), 64'(exp_rd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 64'd1, 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        bit          mdc_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(reg_rdata === 32'h0, "R1 rdata", 64'(reg_rdata), 64'd0);
        check(mdc === 1'b0, "R1 mdc", 64'(mdc), 64'd0);
        check(mdio_oe === 1'b0, "R1 oe", 64'(mdio_oe), 64'd0);
        check(mdio_o === 1'b1, "R1 mdio_o", 64'(mdio_o), 64'd1);

        run_cmd(1'b0, 5'h01, 5'h00, 16'hA55A, 16'h0, 0);   // R5 write
        run_cmd(1'b1, 5'h1F, 5'h02, 16'h0000, 16'hC3E1, 0); // R6 read
        run_cmd(1'b1, 5'h00, 5'h1F, 16'hFFFF, 16'h8001, 0); // R6 corners
        run_cmd(1'b0, 5'h15, 5'h0A, 16'h0000, 16'h0, 0);   // R4 pattern
        run_cmd(1'b0, 5'h0C, 5'h13, 16'h1234, 16'h0, 1);   // R7 poke in write
        run_cmd(1'b1, 5'h07, 5'h11, 16'h0000, 16'h5AA5, 1); // R7 poke in read

        // R9: start bit clear while idle
        snap = reg_rdata;
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 32'h7FFF_FFFF;
        @(negedge clk);
        reg_we = 1'b0;
        mdc_seen = 0;
        repeat (4*HALF) begin
            @(negedge clk);
            if (mdc !== 1'b0) mdc_seen = 1;
        end
        check(reg_rdata === snap, "R9 rdata unchanged", 64'(reg_rdata), 64'(snap));
        check(!mdc_seen, "R9/R8 mdc stays idle", 64'(mdc_seen), 64'd0);
        check(sbq.size() == 0, "R7 queue drained", 64'(sbq.size()), 64'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule